// File: doc/BRIEF.md
# Multi-Entry Hash Sorter

This block files data words into bins selected by a key and later streams back every word held in a requested bin. Any number of words can share a bin. Each stored entry records the identifier of the entry that came before it in the same bin, so each bin is a chain that runs through an entry memory. A per-key head table points at the newest entry of each bin.

Every head carries the event number that was current when it was written. When the event number advances, every bin from the older event reads as empty, and entry allocation starts again at identifier zero. No clearing pass over the tables is needed.

A pop names a key and returns that bin's words one per cycle, newest first. A more-data flag marks every word except the last. While a stream is running, ready is low and further retrieval requests are dropped. A re-pop replays the bin of the most recent pop. Pushes are accepted in any cycle.

Top module: `hash_sorter`

## Requirements
- R1: After reset, ready is 1, and out_valid and out_more are 0.
- R2: An accepted pop of a key that holds N pushed words drives out_valid in the N consecutive cycles after the accepting edge. out_data carries the words newest first.
- R3: out_more is 1 on every streamed word except the last of the bin, and it is 0 whenever out_valid is 0.
- R4: A pop of a key with nothing stored in the current event produces no output word, and ready stays 1.
- R5: Words pushed under different keys never appear in each other's streams, even when their pushes are interleaved.
- R6: ready is 0 in every cycle of a stream in which out_more is 1. A pop or re-pop presented while ready is 0 is ignored and adds no output word.
- R7: An accepted re-pop streams the bin of the key from the most recent accepted pop. It reflects any pushes made to that key since that pop.
- R8: A pulse on ev_next makes every bin empty. A push in the same cycle as the pulse belongs to the new event.
- R9: At most 2^ID_W pushes are stored per event. Pushes beyond that are ignored.
- R10: When a push and a pop name the same key in the same cycle, the pop streams the bin as it was before that push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_next | input | 1 | Advance the event number and restart allocation |
| push | input | 1 | Store push_data under push_key |
| push_key | input | KEY_W | Bin of the pushed word |
| push_data | input | DATA_W | Word to store |
| pop | input | 1 | Start streaming the bin pop_key |
| pop_key | input | KEY_W | Bin to stream |
| repop | input | 1 | Stream the last popped bin again (pop wins if both are set) |
| ready | output | 1 | High when a pop or re-pop will be accepted |
| out_valid | output | 1 | out_data holds a streamed word |
| out_data | output | DATA_W | Streamed word |
| out_more | output | 1 | Another word of the same bin follows next cycle |

## Verification
The first word of a bin is due in the cycle after the clock edge that accepts the pop or re-pop. Each further word follows in the next cycle, with no gaps. ready returns high in the cycle that shows the last word.

The driver presents stimulus on falling edges and, at that moment, queues the words a software model of the bins expects. A monitor samples on every falling edge: each valid word must match the head of that queue, and any word that arrives with the queue empty is a failure. This catches words that come late, come in the wrong order, or should not exist. Directed checks of ready and of the empty-bin cases are also sampled on falling edges, at the cycles worked out above.

// File: rtl/hash_sorter.sv
module hash_sorter #(
  parameter int DATA_W = 28,
  parameter int KEY_W  = 9,
  parameter int ID_W   = 8,
  parameter int EV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_next,
  input  logic              push,
  input  logic [KEY_W-1:0]  push_key,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic [KEY_W-1:0]  pop_key,
  input  logic              repop,
  output logic              ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_more
);
  localparam int NKEY  = 1 << KEY_W;
  localparam int DEPTH = 1 << ID_W;

  logic [ID_W-1:0]   head_id  [NKEY];
  logic [EV_W-1:0]   head_ev  [NKEY];
  logic [NKEY-1:0]   key_seen;
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [ID_W-1:0]   ent_link [DEPTH];
  logic              ent_prev [DEPTH];

  logic [EV_W-1:0] ev_q;
  logic [ID_W:0]   cnt_q;
  logic            busy_q;
  logic [ID_W-1:0] cur_q;
  logic [KEY_W-1:0] last_key_q;

  wire [EV_W-1:0]  ev_now  = ev_next ? ev_q + 1'b1 : ev_q;
  wire [ID_W:0]    cnt_now = ev_next ? '0 : cnt_q;
  wire             do_push = push && (cnt_now < (ID_W+1)'(DEPTH));
  wire [ID_W-1:0]  new_id  = cnt_now[ID_W-1:0];
  wire             push_hit = key_seen[push_key] && (head_ev[push_key] == ev_now);

  wire             start    = ready && (pop || repop);
  wire [KEY_W-1:0] look_key = pop ? pop_key : last_key_q;
  wire             look_hit = key_seen[look_key] && (head_ev[look_key] == ev_now);
  wire [ID_W-1:0]  look_id  = head_id[look_key];

  assign ready = !busy_q;

  always_ff @(posedge clk) begin
    if (do_push) begin
      ent_data[new_id] <= push_data;
      ent_link[new_id] <= head_id[push_key];
      ent_prev[new_id] <= push_hit;
      head_id[push_key] <= new_id;
      head_ev[push_key] <= ev_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_seen   <= '0;
      ev_q       <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      cur_q      <= '0;
      last_key_q <= '0;
      out_valid  <= 1'b0;
      out_more   <= 1'b0;
      out_data   <= '0;
    end else begin
      ev_q      <= ev_now;
      cnt_q     <= do_push ? cnt_now + 1'b1 : cnt_now;
      out_valid <= 1'b0;
      out_more  <= 1'b0;
      if (do_push) key_seen[push_key] <= 1'b1;
      if (busy_q) begin
        out_valid <= 1'b1;
        out_data  <= ent_data[cur_q];
        out_more  <= ent_prev[cur_q];
        busy_q    <= ent_prev[cur_q];
        cur_q     <= ent_link[cur_q];
      end else if (start) begin
        last_key_q <= look_key;
        if (look_hit) begin
          out_valid <= 1'b1;
          out_data  <= ent_data[look_id];
          out_more  <= ent_prev[look_id];
          busy_q    <= ent_prev[look_id];
          cur_q     <= ent_link[look_id];
        end
      end
    end
  end

  p_more_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_more |=> out_valid);
  p_more_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_more);
  p_last_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_more |-> ready);
  p_busy_streams_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> out_valid);
  p_stream_from_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(ready) && $past(pop || repop));
endmodule

// File: tb/hash_sorter_tb_top.sv
module hash_sorter_tb_top;
  localparam int DW = 28, KW = 9, IW = 8, EW = 8;
  localparam int NK = 1 << KW, CAP = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic ev_next = 0, push = 0, pop = 0, repop = 0;
  logic [KW-1:0] push_key = '0, pop_key = '0;
  logic [DW-1:0] push_data = '0;
  logic ready, out_valid, out_more;
  logic [DW-1:0] out_data;

  hash_sorter #(.DATA_W(DW), .KEY_W(KW), .ID_W(IW), .EV_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_next(ev_next), .push(push), .push_key(push_key),
    .push_data(push_data), .pop(pop), .pop_key(pop_key), .repop(repop),
    .ready(ready), .out_valid(out_valid), .out_data(out_data), .out_more(out_more));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, stray = 0, cnt = 0;
  logic [DW-1:0] model [NK][$];
  logic [DW:0] exp_q [$];
  logic [KW-1:0] last_key = '0;
  string exp_tag [$];

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        stray++;
        fails++;
        $display("FAIL R6/R4 stray word: actual=%h expected=none", out_data);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        checks++;
        if ({out_more, out_data} !== e) begin
          fails++;
          $display("FAIL %s (R2/R3 order+more): actual=%b/%h expected=%b/%h",
                   t, out_more, out_data, e[DW], e[DW-1:0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  task automatic expect_key(input logic [KW-1:0] k, input string tag);
    for (int i = 0; i < model[k].size(); i++) begin
      exp_q.push_back({(i < model[k].size() - 1) ? 1'b1 : 1'b0, model[k][i]});
      exp_tag.push_back(tag);
    end
  endtask

  task automatic model_push(input logic [KW-1:0] k, input logic [DW-1:0] d);
    if (cnt < CAP) begin
      model[k].push_front(d);
      cnt++;
    end
  endtask

  task automatic do_push(input logic [KW-1:0] k, input logic [DW-1:0] d);
    push = 1; push_key = k; push_data = d;
    model_push(k, d);
    @(negedge clk);
    push = 0;
  endtask

  task automatic drain();
    int g = 0;
    while ((exp_q.size() != 0 || !ready) && g < 2000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic do_pop(input logic [KW-1:0] k, input string tag);
    pop = 1; pop_key = k; last_key = k;
    expect_key(k, tag);
    @(negedge clk);
    pop = 0;
    drain();
  endtask

  task automatic do_repop(input string tag);
    repop = 1;
    expect_key(last_key, tag);
    @(negedge clk);
    repop = 0;
    drain();
  endtask

  task automatic new_event();
    ev_next = 1;
    foreach (model[i]) model[i].delete();
    cnt = 0;
    @(negedge clk);
    ev_next = 0;
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    check(ready === 1'b1, "R1 ready after reset", ready, 1);
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(out_more === 1'b0, "R1 out_more after reset", out_more, 0);
    rst_n = 1;
    @(negedge clk);

    s = stray;
    do_pop(9'd5, "R4");
    check(stray == s && ready, "R4 empty bin after reset gives no word", stray - s, 0);

    do_push(9'd5, 28'h0000A01);
    do_push(9'd7, 28'h0000B01);
    do_push(9'd5, 28'h0000A02);
    do_push(9'd7, 28'h0000B02);
    do_push(9'd5, 28'h0000A03);
    do_pop(9'd5, "R2 key5");
    do_pop(9'd7, "R5 key7");
    do_push(9'd300, 28'hFFFFFFF);
    do_pop(9'd300, "R2 single");

    pop = 1; pop_key = 9'd5; last_key = 9'd5;
    expect_key(9'd5, "R6 key5");
    @(negedge clk);
    pop = 0;
    check(ready === 1'b0, "R6 ready low mid-stream", ready, 0);
    s = stray;
    pop = 1; pop_key = 9'd7;
    @(negedge clk);
    pop = 0; repop = 1;
    @(negedge clk);
    repop = 0;
    drain();
    check(stray == s && exp_q.size() == 0, "R6 requests while busy ignored", stray - s, 0);

    do_repop("R7 replay key5");
    do_push(9'd5, 28'h0000A04);
    do_repop("R7 replay with new push");

    push = 1; push_key = 9'd7; push_data = 28'h0000B03;
    pop = 1; pop_key = 9'd7; last_key = 9'd7;
    expect_key(9'd7, "R10 same-cycle");
    model_push(9'd7, 28'h0000B03);
    @(negedge clk);
    push = 0; pop = 0;
    drain();
    do_pop(9'd7, "R10 after push");

    ev_next = 1;
    foreach (model[i]) model[i].delete();
    cnt = 0;
    push = 1; push_key = 9'd9; push_data = 28'h0000C01;
    model_push(9'd9, 28'h0000C01);
    @(negedge clk);
    ev_next = 0; push = 0;
    s = stray;
    do_pop(9'd5, "R8");
    check(stray == s, "R8 old bin empty after event advance", stray - s, 0);
    do_repop("R8 repop old bin");
    check(stray == s, "R8 repop of old bin empty", stray - s, 0);
    do_pop(9'd9, "R8 push in advance cycle");

    new_event();
    for (int i = 0; i < CAP + 3; i++) do_push(9'd11, DW'(i + 100));
    check(model[11].size() == CAP, "R9 model capacity", model[11].size(), CAP);
    do_pop(9'd11, "R9 capacity");
    s = stray;
    do_pop(9'd12, "R9");
    check(stray == s, "R9 overflow push stored nowhere", stray - s, 0);

    check(exp_q.size() == 0, "R2 all expected words seen", exp_q.size(), 0);
    finish_run();
  end
endmodule